// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the register and transfer core of a small processor in which every storage element sits on one shared internal bus. It holds four general registers, a program counter, an instruction register, a memory address register, a memory data register, and three hidden staging registers. Programs cannot see the staging registers: Y holds the first ALU operand, Z captures the ALU result, and TEMP is a scratch value. An external sequencer supplies a control word each cycle. The word holds one out-enable bit per bus source, one in-enable bit per destination, an ALU operation code, and read and write request bits. The block decodes nothing on its own.

Any ALU operation takes several bus steps. First the first operand is moved into Y. Next the second operand is placed on the bus while Z captures the result. Last, Z drives the result to its destination. Memory traffic is addressed through MAR, and its data passes through MDR. A read or write request stays asserted until the memory answers with a completion pulse. For a read, MDR captures the returned word on that same edge. The bus value is brought out on a port so that the sequencer and the bench can watch each transfer.

Top module: `sbus_core`

## Requirements
- R1: After reset, every register holds zero, memRd and memWr are low, and busView is zero.
- R2: cwOut selects the bus source, with bit 0..3 = R0..R3, 4 = PC, 5 = MDR, 6 = IR, 7 = Z and 8 = TEMP. busView shows the selected register's value in the same cycle and reads zero when no bit is set. At most one bit may be set in any cycle.
- R3: cwIn selects the destinations, with bit 0..3 = R0..R3, 4 = PC, 5 = MAR, 6 = MDR, 7 = IR, 8 = Y, 9 = Z and 10 = TEMP. Every selected destination other than Z loads the bus value at the clock edge, and several destinations may load at once. Unselected registers keep their values.
- R4: With cwAluOp = 01 and the Z bit of cwIn set, Z loads Y + bus modulo 2^WIDTH.
- R5: With cwAluOp = 10 and the Z bit of cwIn set, Z loads Y - bus modulo 2^WIDTH.
- R6: With the Z bit of cwIn set, cwAluOp = 00 loads the bus value into Z and cwAluOp = 11 loads Y into Z.
- R7: A cwRead accepted on an edge raises memRd from the next cycle, with memAddr equal to MAR. memRd stays high until memMfc is sampled high. On that edge MDR loads memRdata, and memRd then falls.
- R8: A cwWrite accepted on an edge raises memWr from the next cycle, with memAddr equal to MAR and memWdata equal to MDR. memWr stays high until memMfc is sampled high and then falls.
- R9: In the cycle that completes a read, MDR takes memRdata even when the MDR bit of cwIn is also set.
- R10: A request raised while a transfer is outstanding, including the cycle in which it completes, is ignored. When cwRead and cwWrite are both set, only the read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cwOut | input | 9 | Out-enable strobes, one per bus source |
| cwIn | input | 11 | In-enable strobes, one per destination |
| cwAluOp | input | 2 | ALU operation code |
| cwRead | input | 1 | Memory read request |
| cwWrite | input | 1 | Memory write request |
| memAddr | output | WIDTH | Memory address, from MAR |
| memWdata | output | WIDTH | Memory write data, from MDR |
| memRdata | input | WIDTH | Memory read data |
| memRd | output | 1 | Read in progress |
| memWr | output | 1 | Write in progress |
| memMfc | input | 1 | Memory function complete |
| busView | output | WIDTH | Current value of the internal bus |

## Verification
The hardest case to reach from the ports is the completing cycle of a read. In that cycle three things meet: the memory data, a competing bus load into MDR, and a fresh request that must be dropped. The bench brings these about by holding a read pending for a chosen number of idle cycles. It raises the completion pulse on a chosen cycle, and in that same cycle it drives the MDR in-enable from another register. Since the bench has no direct data input, registers are seeded only through memory reads. These reads are mixed into a long random run of bus transfers, so arbitrary values reach every register and the wrap-around cases of the ALU.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  // destination (in-enable) positions
  localparam int NUM_IN   = 11;
  localparam int IDX_R0   = 0;
  localparam int IDX_PC   = 4;
  localparam int IDX_MAR  = 5;
  localparam int IDX_MDR  = 6;
  localparam int IDX_IR   = 7;
  localparam int IDX_Y    = 8;
  localparam int IDX_Z    = 9;
  localparam int IDX_TEMP = 10;

  // bus source (out-enable) positions
  localparam int NUM_OUT  = 9;
  localparam int OUT_PC   = 4;
  localparam int OUT_MDR  = 5;
  localparam int OUT_IR   = 6;
  localparam int OUT_Z    = 7;
  localparam int OUT_TEMP = 8;

  typedef enum logic [1:0] {
    ALU_PASS_BUS = 2'b00,
    ALU_ADD      = 2'b01,
    ALU_SUB      = 2'b10,
    ALU_PASS_Y   = 2'b11
  } aluOp_e;

  typedef struct packed {
    logic [NUM_OUT-1:0] drive;
    logic [NUM_IN-1:0]  load;
    aluOp_e             aluOp;
    logic               mdrFromMem;
  } strobes_t;

  // storage index that a bus source position reads from
  function automatic int srcStore(int o);
    case (o)
      OUT_PC:   return IDX_PC;
      OUT_MDR:  return IDX_MDR;
      OUT_IR:   return IDX_IR;
      OUT_Z:    return IDX_Z;
      OUT_TEMP: return IDX_TEMP;
      default:  return IDX_R0 + o;
    endcase
  endfunction

endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] cwOut,
  input  logic [NUM_IN-1:0]  cwIn,
  input  logic [1:0]         cwAluOp,
  input  logic               cwRead,
  input  logic               cwWrite,
  input  logic               memMfc,
  output strobes_t           stb,
  output logic               memRd,
  output logic               memWr
);

  logic rdPend, wrPend, busy;

  assign busy = rdPend | wrPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      wrPend <= 1'b0;
    end else if (busy) begin
      if (memMfc) begin
        rdPend <= 1'b0;
        wrPend <= 1'b0;
      end
    end else begin
      rdPend <= cwRead;
      wrPend <= cwWrite & ~cwRead;
    end
  end

  always_comb begin
    stb.drive      = cwOut;
    stb.load       = cwIn;
    stb.aluOp      = aluOp_e'(cwAluOp);
    stb.mdrFromMem = rdPend & memMfc;
  end

  assign memRd = rdPend;
  assign memWr = wrPend;

  // R2: the control word may enable at most one bus driver
  p_single_driver_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cwOut));

  // R7: a read stays requested until the memory completes it
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memMfc) |=> memRd);

  // R7: a read is released after completion
  p_rd_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memMfc) |=> !memRd);

  // R8: a write stays requested until the memory completes it
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memMfc) |=> memWr);

  // R10: a write request during a pending read is dropped
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && cwWrite) |=> !memWr);

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [WIDTH-1:0] memRdata,
  output logic [WIDTH-1:0] busView,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] memWdata
);

  logic [WIDTH-1:0] regView [NUM_IN];
  logic [WIDTH-1:0] busV;
  logic [WIDTH-1:0] aluRes;

  // one-hot multiplexer: gated sources OR-ed together, zero when idle
  always_comb begin
    busV = '0;
    for (int j = 0; j < NUM_OUT; j++) begin
      busV = busV | ({WIDTH{stb.drive[j]}} & regView[srcStore(j)]);
    end
  end

  always_comb begin
    case (stb.aluOp)
      ALU_ADD:    aluRes = regView[IDX_Y] + busV;
      ALU_SUB:    aluRes = regView[IDX_Y] - busV;
      ALU_PASS_Y: aluRes = regView[IDX_Y];
      default:    aluRes = busV;
    endcase
  end

  for (genvar k = 0; k < NUM_IN; k++) begin : g_reg
    logic [WIDTH-1:0] q;
    if (k == IDX_Z) begin : g_z
      always_ff @(posedge clk) begin
        if (!rstN)            q <= '0;
        else if (stb.load[k]) q <= aluRes;
      end
    end else if (k == IDX_MDR) begin : g_mdr
      always_ff @(posedge clk) begin
        if (!rstN)               q <= '0;
        else if (stb.mdrFromMem) q <= memRdata;
        else if (stb.load[k])    q <= busV;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)            q <= '0;
        else if (stb.load[k]) q <= busV;
      end
    end
    assign regView[k] = q;
  end

  assign busView  = busV;
  assign memAddr  = regView[IDX_MAR];
  assign memWdata = regView[IDX_MDR];

  // R9: memory data wins the MDR load on a completing read
  p_mdr_mem_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.mdrFromMem |=> (regView[IDX_MDR] == $past(memRdata)));

  // R4: Z captures the sum of Y and the bus
  p_add_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load[IDX_Z] && stb.aluOp == ALU_ADD)
      |=> (regView[IDX_Z] == WIDTH'($past(regView[IDX_Y]) + $past(busV))));

  // R3: an unselected register holds its value
  p_hold_temp_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load[IDX_TEMP] |=> $stable(regView[IDX_TEMP]));

endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] cwOut,
  input  logic [NUM_IN-1:0]  cwIn,
  input  logic [1:0]         cwAluOp,
  input  logic               cwRead,
  input  logic               cwWrite,
  output logic [WIDTH-1:0]   memAddr,
  output logic [WIDTH-1:0]   memWdata,
  input  logic [WIDTH-1:0]   memRdata,
  output logic               memRd,
  output logic               memWr,
  input  logic               memMfc,
  output logic [WIDTH-1:0]   busView
);

  strobes_t stb;

  sbus_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cwOut   (cwOut),
    .cwIn    (cwIn),
    .cwAluOp (cwAluOp),
    .cwRead  (cwRead),
    .cwWrite (cwWrite),
    .memMfc  (memMfc),
    .stb     (stb),
    .memRd   (memRd),
    .memWr   (memWr)
  );

  sbus_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memRdata (memRdata),
    .busView  (busView),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: tb/sim_sbus_core.sv
`timescale 1ns/1ps
module sim_sbus_core;
  import sbus_pkg::*;

  localparam int W = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_OUT-1:0] cwOut = '0;
  logic [NUM_IN-1:0]  cwIn = '0;
  logic [1:0]         cwAluOp = 2'b00;
  logic               cwRead = 1'b0;
  logic               cwWrite = 1'b0;
  logic               memMfc = 1'b0;
  logic [W-1:0]       memRdata = '0;
  logic [W-1:0]       memAddr, memWdata, busView;
  logic               memRd, memWr;

  int nChk = 0;
  int nBad = 0;
  logic [W-1:0] m [NUM_IN];

  always #4 clk = ~clk;

  sbus_core #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .cwOut(cwOut), .cwIn(cwIn), .cwAluOp(cwAluOp),
    .cwRead(cwRead), .cwWrite(cwWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRd(memRd), .memWr(memWr), .memMfc(memMfc),
    .busView(busView)
  );

  task automatic chkEq(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_IN-1:0] bitIn(int k);
    logic [NUM_IN-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  function automatic int storeOf(int o);
    case (o)
      4: return IDX_PC;
      5: return IDX_MDR;
      6: return IDX_IR;
      7: return IDX_Z;
      8: return IDX_TEMP;
      default: return o;
    endcase
  endfunction

  function automatic logic [W-1:0] aluRef(logic [1:0] op, logic [W-1:0] y, logic [W-1:0] b);
    case (op)
      2'b01:   return y + b;
      2'b10:   return y - b;
      2'b11:   return y;
      default: return b;
    endcase
  endfunction

  // one bus step; starts and ends just after a falling edge
  task automatic step(int src, logic [NUM_IN-1:0] ld, logic [1:0] op,
                      bit rd = 0, bit wr = 0);
    logic [W-1:0] b, r;
    cwOut = '0;
    if (src >= 0) cwOut[src] = 1'b1;
    cwIn = ld; cwAluOp = op; cwRead = rd; cwWrite = wr;
    b = (src >= 0) ? m[storeOf(src)] : '0;
    r = aluRef(op, m[IDX_Y], b);
    #1 chkEq("R2 bus value during step", busView, b);
    @(posedge clk); @(negedge clk);
    cwOut = '0; cwIn = '0; cwRead = 1'b0; cwWrite = 1'b0; cwAluOp = 2'b00;
    for (int k = 0; k < NUM_IN; k++)
      if (ld[k]) m[k] = (k == IDX_Z) ? r : b;
  endtask

  task automatic peek(int src, string tag);
    cwOut = '0;
    cwOut[src] = 1'b1;
    #1 chkEq(tag, busView, m[storeOf(src)]);
    cwOut = '0;
    @(negedge clk);
  endtask

  task automatic memReadSeq(int addrSrc, int lat, logic [W-1:0] data,
                            bit mdrClash, bit busyWrite);
    step(addrSrc, bitIn(IDX_MAR), 2'b00, 1, 0);
    chkEq("R7 memRd raised", W'(memRd), W'(1));
    chkEq("R7 memAddr is MAR", memAddr, m[IDX_MAR]);
    for (int i = 0; i < lat; i++) begin
      chkEq("R7 memRd held", W'(memRd), W'(1));
      if (busyWrite && i == 0) cwWrite = 1'b1;
      @(negedge clk);
      if (busyWrite && i == 0) begin
        cwWrite = 1'b0;
        chkEq("R10 write ignored while read pending", W'(memWr), W'(0));
      end
    end
    memRdata = data;
    memMfc = 1'b1;
    if (mdrClash) begin
      cwOut = '0; cwOut[0] = 1'b1;
      cwIn = bitIn(IDX_MDR);
    end
    @(posedge clk); @(negedge clk);
    memMfc = 1'b0; cwOut = '0; cwIn = '0;
    m[IDX_MDR] = data;
    chkEq("R7 memRd released", W'(memRd), W'(0));
    peek(OUT_MDR, mdrClash ? "R9 MDR took memory data" : "R7 MDR read data");
  endtask

  task automatic memWriteSeq(int lat);
    step(-1, '0, 2'b00, 0, 1);
    chkEq("R8 memWr raised", W'(memWr), W'(1));
    chkEq("R8 memRd low", W'(memRd), W'(0));
    chkEq("R8 memWdata is MDR", memWdata, m[IDX_MDR]);
    chkEq("R8 memAddr is MAR", memAddr, m[IDX_MAR]);
    for (int i = 0; i < lat; i++) begin
      chkEq("R8 memWr held", W'(memWr), W'(1));
      @(negedge clk);
    end
    memMfc = 1'b1;
    @(posedge clk); @(negedge clk);
    memMfc = 1'b0;
    chkEq("R8 memWr released", W'(memWr), W'(0));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    for (int k = 0; k < NUM_IN; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chkEq("R1 memRd after reset", W'(memRd), W'(0));
    chkEq("R1 memWr after reset", W'(memWr), W'(0));
    chkEq("R1 bus idle zero", busView, '0);
    chkEq("R1 MAR zero", memAddr, '0);
    @(negedge clk);
    for (int o = 0; o < NUM_OUT; o++) peek(o, "R1 register zero after reset");

    // seed visible registers through memory reads
    for (int k = 0; k < NUM_IN; k++) begin
      if (k == IDX_MAR || k == IDX_MDR || k == IDX_Y || k == IDX_Z) continue;
      memReadSeq(-1, k % 3, $urandom, 0, 0);
      step(OUT_MDR, bitIn(k), 2'b00);
    end
    for (int o = 0; o < NUM_OUT; o++) peek(o, "R3 seeded register");

    // R4: R3 = R1 + R2 in three steps
    step(1, bitIn(IDX_Y), 2'b00);
    step(2, bitIn(IDX_Z), 2'b01);
    step(OUT_Z, bitIn(3), 2'b00);
    peek(3, "R4 add result in R3");

    // R4: wrap-around with all-ones operands
    memReadSeq(-1, 2, 16'hFFFF, 0, 0);
    step(OUT_MDR, bitIn(IDX_TEMP) | bitIn(IDX_Y), 2'b00);
    step(OUT_TEMP, bitIn(IDX_Z), 2'b01);
    peek(OUT_Z, "R4 add wraps to FFFE");
    chkEq("R4 wrap value", m[IDX_Z], 16'hFFFE);

    // R5: zero minus R2 wraps
    step(1, bitIn(IDX_Y), 2'b00);
    step(1, bitIn(IDX_Z), 2'b10);
    peek(OUT_Z, "R5 self subtract zero");
    step(OUT_Z, bitIn(IDX_Y), 2'b00);
    step(2, bitIn(IDX_Z), 2'b10);
    peek(OUT_Z, "R5 negative wraps");

    // R6: pass codes
    step(0, bitIn(IDX_Z), 2'b00);
    peek(OUT_Z, "R6 pass bus");
    step(3, bitIn(IDX_Y), 2'b00);
    step(1, bitIn(IDX_Z), 2'b11);
    peek(OUT_Z, "R6 pass Y");

    // R3: several destinations from one bus value; idle step loads nothing
    step(OUT_PC, bitIn(0) | bitIn(3) | bitIn(IDX_TEMP), 2'b00);
    peek(0, "R3 multi load R0");
    peek(3, "R3 multi load R3");
    peek(OUT_TEMP, "R3 multi load TEMP");
    step(-1, bitIn(1), 2'b00);
    peek(1, "R3 load from idle bus gives zero");
    peek(2, "R3 unselected register holds");

    // R7 fetch: address in R2, data to R1
    memReadSeq(2, 3, 16'hA5C3, 0, 0);
    step(OUT_MDR, bitIn(1), 2'b00);
    peek(1, "R7 fetched word in R1");
    // R9 and R10 corners
    memReadSeq(0, 2, 16'h3C5A, 1, 0);
    memReadSeq(3, 2, 16'h0F0F, 0, 1);
    chkEq("R10 no write after ignored request", W'(memWr), W'(0));
    // R10: read and write together start only the read
    step(-1, '0, 2'b00, 1, 1);
    chkEq("R10 read wins", W'(memRd), W'(1));
    chkEq("R10 write dropped", W'(memWr), W'(0));
    memRdata = 16'h1357; memMfc = 1'b1;
    cwWrite = 1'b1;
    @(posedge clk); @(negedge clk);
    memMfc = 1'b0; cwWrite = 1'b0;
    m[IDX_MDR] = 16'h1357;
    chkEq("R10 request in completing cycle ignored", W'(memWr), W'(0));
    chkEq("R10 read done", W'(memRd), W'(0));
    // R8 write
    step(3, bitIn(IDX_MAR), 2'b00);
    step(1, bitIn(IDX_MDR), 2'b00);
    memWriteSeq(0);
    memWriteSeq(3);

    // constrained random run
    for (int it = 0; it < 400; it++) begin
      int src;
      logic [NUM_IN-1:0] ld;
      src = int'($urandom_range(0, NUM_OUT));
      if (src == NUM_OUT) src = -1;
      ld = NUM_IN'($urandom) & NUM_IN'($urandom);
      step(src, ld, 2'($urandom));
      peek(int'($urandom_range(0, NUM_OUT - 1)), "R3/R4/R5/R6 random register");
      chkEq("R3 random MAR", memAddr, m[IDX_MAR]);
      if (it % 25 == 0) begin
        memReadSeq(int'($urandom_range(0, NUM_OUT - 1)), int'($urandom_range(0, 3)),
                   $urandom, it % 50 == 0, 0);
        step(OUT_MDR, bitIn(int'($urandom_range(0, 3))), 2'b00);
      end
    end
    for (int o = 0; o < NUM_OUT; o++) peek(o, "R3 final register");

    summary();
    $finish;
  end

endmodule